// File: doc/BRIEF.md
# Glitch-free card clock selector

The block drives the clock of an inserted smart card and a clock output for the host. It works from three sources: a crystal clock, an internal oscillator clock and an external strobe. All three are treated as digital inputs and sampled by a fast system clock `clk`. A run/sleep input, a strobe-select input and a two-bit divide code choose one of these outputs for the card clock: the oscillator halved, the crystal halved, the crystal quartered, a stopped-low level, or the strobe passed straight through. The host output follows the same inputs.

A new selection never cuts a card clock phase short. The block waits until the card clock is low. It then holds the card clock low until the new source has a falling edge, so the first pulse from the new source is full length. A gate input from the activation sequencer uses the same mechanism. When the gate is low the card clock is held low. When the gate is released, the clock starts again on a clean boundary.

Top module: `card_clk_sel`

## Requirements
- R1: While `rst_n` is low, `card_clk` and `host_clk` are both low.
- R2: With `run_mode`=1, `use_strobe`=0 and {`div_hi`,`div_lo`}=2'b10, `card_clk` is the oscillator divided by 2. `host_clk` is also the oscillator divided by 2.
- R3: With `run_mode`=1, `use_strobe`=0 and {`div_hi`,`div_lo`}=2'b00, `card_clk` is the crystal divided by 4, and `host_clk` is the crystal undivided.
- R4: With `run_mode`=1, `use_strobe`=0 and {`div_hi`,`div_lo`}=2'b01, `card_clk` is the crystal divided by 2, and `host_clk` is the crystal undivided.
- R5: With `run_mode`=1, `use_strobe`=0 and {`div_hi`,`div_lo`}=2'b11, `card_clk` stays low, and `host_clk` is the crystal undivided.
- R6: With `run_mode`=1 and `use_strobe`=1, `card_clk` follows the strobe for every divide code, and `host_clk` is the crystal undivided.
- R7: With `run_mode`=0, `card_clk` stays low and `host_clk` is the oscillator divided by 2, for every other setting.
- R8: A change of selection takes effect only while `card_clk` is low. No high or low phase of `card_clk` is shorter than the shortest half-period of any selectable source.
- R9: While `gate_en` is low, `card_clk` stays low. After `gate_en` rises, the first high phase of `card_clk` is a full half-period of the selected source.
- R10: In every divided mode the high and low phases of `card_clk` are equal in length, which gives a 50 percent duty cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xtal_i | input | 1 | Crystal clock, sampled as data |
| osc_i | input | 1 | Internal oscillator clock, sampled as data |
| strobe_i | input | 1 | External strobe clock, sampled as data |
| run_mode | input | 1 | 1 = normal operation, 0 = sleep |
| use_strobe | input | 1 | 1 = card clock taken from the strobe |
| div_hi | input | 1 | Upper bit of the divide code |
| div_lo | input | 1 | Lower bit of the divide code |
| gate_en | input | 1 | Sequencer gate; 0 forces the card clock low |
| card_clk | output | 1 | Clock to the card |
| host_clk | output | 1 | Clock output to the host |

## Verification
The assertions check on every cycle that the internal selection changes only while the card clock is low. They also check that the card clock cannot rise from a low level in sleep mode, while the gate is closed, or under the stop code. The bench sweeps every combination of mode, strobe-select and divide code. For each combination it measures the phase lengths of both outputs against the known source periods. Two things only the bench scenarios can show: the absence of runt phases under rapid code changes, and a full-length first pulse after the gate is released.

// File: rtl/card_clk_sel.sv
module card_clk_sel #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic xtal_i,
  input  logic osc_i,
  input  logic strobe_i,
  input  logic run_mode,
  input  logic use_strobe,
  input  logic div_hi,
  input  logic div_lo,
  input  logic gate_en,
  output logic card_clk,
  output logic host_clk
);
  localparam int SW = (SYNC < 1) ? 1 : SYNC;

  typedef enum logic [2:0] {S_STOP, S_OSC2, S_X4, S_X2, S_STRB} src_t;

  logic [SW:0] xs, os, ss;
  logic [1:0]  xcnt;
  logic        ohalf;
  src_t        cur, cur_n, want;
  logic        hold, hold_n, prev_sv, card_r, host_r;
  logic        sv_cur, sv_nxt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      xs <= '0; os <= '0; ss <= '0;
    end else begin
      xs <= {xs[SW-1:0], xtal_i};
      os <= {os[SW-1:0], osc_i};
      ss <= {ss[SW-1:0], strobe_i};
    end

  wire x_rise = xs[SW-1] & ~xs[SW];
  wire o_rise = os[SW-1] & ~os[SW];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      xcnt  <= '0;
      ohalf <= 1'b0;
    end else begin
      if (x_rise) xcnt <= xcnt + 2'd1;
      if (o_rise) ohalf <= ~ohalf;
    end

  function automatic logic pick(src_t c, logic o2, logic x4, logic x2, logic st);
    case (c)
      S_OSC2:  return o2;
      S_X4:    return x4;
      S_X2:    return x2;
      S_STRB:  return st;
      default: return 1'b0;
    endcase
  endfunction

  always_comb begin
    if (!run_mode || !gate_en) want = S_STOP;
    else if (use_strobe)       want = S_STRB;
    else
      case ({div_hi, div_lo})
        2'b10:   want = S_OSC2;
        2'b00:   want = S_X4;
        2'b01:   want = S_X2;
        default: want = S_STOP;
      endcase
  end

  always_comb begin
    sv_cur = pick(cur, ohalf, xcnt[1], xcnt[0], ss[SW-1]);
    cur_n  = cur;
    hold_n = hold;
    if (want != cur && !card_r) begin
      cur_n  = want;
      hold_n = 1'b1;
    end else if (hold && (cur == S_STOP || (prev_sv && !sv_cur))) begin
      hold_n = 1'b0;
    end
    sv_nxt = pick(cur_n, ohalf, xcnt[1], xcnt[0], ss[SW-1]);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cur     <= S_STOP;
      hold    <= 1'b1;
      prev_sv <= 1'b0;
      card_r  <= 1'b0;
      host_r  <= 1'b0;
    end else begin
      cur     <= cur_n;
      hold    <= hold_n;
      prev_sv <= (cur_n != cur) ? 1'b0 : sv_cur;
      card_r  <= !hold_n && sv_nxt;
      host_r  <= (!run_mode || (!use_strobe && div_hi && !div_lo)) ? ohalf : xs[SW-1];
    end

  assign card_clk = card_r;
  assign host_clk = host_r;

  assert_switch_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cur != $past(cur)) |-> !$past(card_r));

  assert_sleep_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_mode && !card_clk) |=> !card_clk);

  assert_gate_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_en && !card_clk) |=> !card_clk);

  assert_stop_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_mode && gate_en && !use_strobe && div_hi && div_lo && !card_clk) |=> !card_clk);
endmodule

// File: tb/card_clk_sel_test.sv
module card_clk_sel_test;
  localparam int XH = 4, OH = 6, SH = 5, MINPH = 5;

  logic clk = 0, rst_n = 0;
  logic xtal_i = 0, osc_i = 0, strobe_i = 0;
  logic run_mode = 1, use_strobe = 0, div_hi = 0, div_lo = 1, gate_en = 1;
  logic card_clk, host_clk;
  int checks = 0, failures = 0, runts = 0, run = 1000;
  logic mon_en = 0, last = 0, done = 0;

  card_clk_sel uut (.clk(clk), .rst_n(rst_n), .xtal_i(xtal_i), .osc_i(osc_i),
    .strobe_i(strobe_i), .run_mode(run_mode), .use_strobe(use_strobe),
    .div_hi(div_hi), .div_lo(div_lo), .gate_en(gate_en),
    .card_clk(card_clk), .host_clk(host_clk));

  always #2 clk = ~clk;

  initial forever begin repeat (XH) @(negedge clk); xtal_i = ~xtal_i; end
  initial forever begin repeat (OH) @(negedge clk); osc_i = ~osc_i; end
  initial forever begin repeat (SH) @(negedge clk); strobe_i = ~strobe_i; end

  always @(negedge clk) begin
    if (card_clk != last) begin
      if (mon_en && run < MINPH) runts++;
      run = 1;
    end else if (run < 100000) run++;
    last = card_clk;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic sig(input bit which);
    return which ? host_clk : card_clk;
  endfunction

  task automatic meas(input bit which, output int hi, output int lo);
    int g = 0;
    hi = -1; lo = -1;
    while (sig(which) && g < 2000) begin @(negedge clk); g++; end
    while (!sig(which) && g < 2000) begin @(negedge clk); g++; end
    if (g >= 2000) return;
    hi = 0;
    while (sig(which) && g < 2000) begin @(negedge clk); hi++; g++; end
    lo = 0;
    while (!sig(which) && g < 2000) begin @(negedge clk); lo++; g++; end
  endtask

  task automatic low_for(input int n, output int highs);
    highs = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (card_clk) highs++; end
  endtask

  initial begin
    int hi, lo, cexp, hexp, highs;
    string tag;
    repeat (5) @(negedge clk);
    chk(card_clk == 0 && host_clk == 0, "R1 reset", {card_clk, host_clk}, 0);
    rst_n = 1;
    repeat (20) @(negedge clk);
    mon_en = 1;

    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 2; s++)
        for (int d = 0; d < 4; d++) begin
          run_mode = m[0]; use_strobe = s[0]; {div_hi, div_lo} = d[1:0];
          repeat (80) @(negedge clk);
          if (m == 0) begin cexp = 0; tag = "R7"; end
          else if (s == 1) begin cexp = SH; tag = "R6"; end
          else if (d == 2) begin cexp = 2*OH; tag = "R2"; end
          else if (d == 0) begin cexp = 4*XH; tag = "R3"; end
          else if (d == 1) begin cexp = 2*XH; tag = "R4"; end
          else begin cexp = 0; tag = "R5"; end
          hexp = (m == 0 || (s == 0 && d == 2)) ? 2*OH : XH;
          if (cexp == 0) begin
            low_for(100, highs);
            chk(highs == 0, {tag, " card low"}, highs, 0);
          end else begin
            meas(0, hi, lo);
            chk(hi == cexp && lo == cexp, {tag, " R10 card phases"}, hi*1000+lo, cexp*1000+cexp);
          end
          meas(1, hi, lo);
          chk(hi == hexp && lo == hexp, {tag, " host phases"}, hi*1000+lo, hexp*1000+hexp);
        end

    run_mode = 1; use_strobe = 0; {div_hi, div_lo} = 2'b01;
    repeat (40) @(negedge clk);
    while (!card_clk) @(negedge clk);
    gate_en = 0;
    repeat (40) @(negedge clk);
    low_for(60, highs);
    chk(highs == 0, "R9 gate closed", highs, 0);
    gate_en = 1;
    meas(0, hi, lo);
    chk(hi == 2*XH && lo == 2*XH, "R9 first pulse after release", hi*1000+lo, 2*XH*1001);

    for (int k = 0; k < 60; k++) begin
      {div_hi, div_lo} = k[1:0] ^ k[3:2];
      use_strobe = (k % 5 == 0);
      run_mode = (k % 11 != 3);
      gate_en = (k % 7 != 2);
      repeat (3 + k % 9) @(negedge clk);
    end
    run_mode = 1; gate_en = 1; use_strobe = 0; {div_hi, div_lo} = 2'b00;
    repeat (100) @(negedge clk);
    chk(runts == 0, "R8 no short phase", runts, 0);
    meas(0, hi, lo);
    chk(hi == 4*XH && lo == 4*XH, "R8 R3 settled after stress", hi*1000+lo, 4*XH*1001);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule